// File: doc/BRIEF.md
# Calibrated PWM DAC Controller

This block drives an external analog level with a single-bit pulse stream. A free-running counter compares against an active pulse width. The fraction of each period spent high sets the average value, which an off-chip RC network smooths into a DC level. The block also drives the complement of the stream for a second routing path.

Software does not supply raw pulse-width codes. It presents a requested output value on a valid/ready stream. A linear calibration stage turns that value into a code using a signed zero-output offset and an unsigned counts-per-unit gain held in fixed point. The result is clamped to the legal range. Period and pulse-width changes are shadowed and switch over only at the counter wrap, so no period is ever cut short.

A polarity-control output drives a downstream gain switch. It is one of eight modulation sources, chosen by a selector code, XORed with a sign bit. The sources include the block's own stream and its complement.

Top module: `pwmdac_ctrl`

## Requirements
- R1: The counter steps from 0 to P-1 and then returns to 0, so one output period lasts P clock cycles. A period value of 0 behaves as a period of 1. After reset the active and pending period are both 4095.
- R2: `pwm_o` is 1 exactly in the cycles where the counter value is below the active pulse width.
- R3: An active pulse width of 0 keeps `pwm_o` low for the whole period. An active pulse width of P or more keeps it high for the whole period.
- R4: `pwm_n_o` is always the logical inverse of `pwm_o`.
- R5: A period write (`per_we`) or an accepted request changes only the pending copy. The pending copies become active in the cycle where the counter is back at 0, right after the wrap.
- R6: An accepted request value V gives code = floor((V*G + 128) / 256) + Z. G is the 16-bit gain with 8 fractional bits, and Z is the 17-bit two's-complement zero code.
- R7: The code is clamped to the range 0 up to the pending period as it was before the accepting edge.
- R8: `req_ready` is always 1, so the block never back-pressures. Every beat with `req_valid` high is accepted and replaces the pending code, and the last beat before a wrap wins. With `req_valid` low the pending code holds.
- R9: `mod_code` is 4 bits and is loaded with `mod_sign` on `mod_we`. Code 0 and codes 9 to 15 disable the selector, and the selected signal is then 0. Code k (1 to 8) picks source k-1. Sources 0 to 5 are `mod_in[0]` to `mod_in[5]`: global lines A and B, then four comparators. Source 6 is `pwm_o` and source 7 is `pwm_n_o`. Code 1 therefore enables modulation from global line A.
- R10: `pol_o` equals the selected signal XOR the sign bit. A value of 1 requests the high reference (gain +1) and 0 requests the low reference (gain -1).
- R11: Reset (`rst_n` low, synchronous) clears the counter, the active and pending pulse width, the selector code and the sign. The outputs then read `pwm_o`=0, `pwm_n_o`=1 and `pol_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Requested-value beat present |
| req_ready | output | 1 | Always 1; beat accepted |
| req_value | input | 16 | Requested output value |
| cal_zero | input | 17 | Signed zero-output code |
| cal_gain | input | 16 | Counts per unit, 8 fractional bits |
| per_we | input | 1 | Load pending period |
| per_value | input | 16 | Period in clock cycles |
| mod_we | input | 1 | Load selector code and sign |
| mod_code | input | 4 | Modulation selector code |
| mod_sign | input | 1 | Sign bit XORed into polarity |
| mod_in | input | 6 | External modulation sources |
| pwm_o | output | 1 | Pulse-width-modulated stream |
| pwm_n_o | output | 1 | Inverted stream |
| pol_o | output | 1 | Polarity control |

## Verification
The hardest situation to reach from the ports is a pending update that lands close to the wrap. This covers a period shrink while the old period is still running, and two requests arriving back to back so that only the later one may take effect. The stimulus shortens the period to a few cycles, so wraps come often. It then issues writes at arbitrary phases of the count, including a period write that lowers the clamp limit while a larger pulse width is still active. The reference model follows the count cycle by cycle and checks every output on every clock. Any wrong hand-over instant or clamp limit therefore shows up as a mismatch.

// File: rtl/pwmdac_pkg.sv
package pwmdac_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned GAIN_W = 16;
  localparam int unsigned FRAC_W = 8;
  localparam int unsigned NSRC   = 8;
  localparam int unsigned SEL_W  = 4;
  localparam int unsigned NEXT   = 6;
  localparam logic [CNT_W-1:0] DEF_PERIOD = 16'd4095;
endpackage

// File: rtl/pwmdac_cal.sv
module pwmdac_cal #(
  parameter int unsigned DW = 16,
  parameter int unsigned GW = 16,
  parameter int unsigned FW = 8,
  parameter int unsigned CW = 16
) (
  input  logic [DW-1:0] value,
  input  logic [GW-1:0] gain,
  input  logic [CW:0]   zero,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] code
);
  localparam int unsigned PW = DW + GW;
  localparam int unsigned SW = PW + 2;
  localparam logic [PW:0] HALF = (PW+1)'(1) << (FW - 1);

  logic [PW-1:0]        prod;
  logic [PW:0]          rsum;
  logic [PW:0]          rnd;
  logic signed [SW-1:0] total;
  logic signed [SW-1:0] lim_s;

  always_comb begin
    prod  = PW'(value) * PW'(gain);
    rsum  = {1'b0, prod} + HALF;
    rnd   = rsum >> FW;
    total = $signed({1'b0, rnd}) + $signed({{(SW-CW-1){zero[CW]}}, zero});
    lim_s = $signed({{(SW-CW){1'b0}}, limit});
    if (total < 0)          code = '0;
    else if (total > lim_s) code = limit;
    else                    code = total[CW-1:0];
  end
endmodule

// File: rtl/pwmdac_core.sv
module pwmdac_core #(
  parameter int unsigned CW = 16,
  parameter logic [CW-1:0] RST_PER = 16'd4095
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          per_we,
  input  logic [CW-1:0] per_in,
  input  logic          pw_we,
  input  logic [CW-1:0] pw_in,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] per_act,
  output logic [CW-1:0] pw_act,
  output logic [CW-1:0] per_sh,
  output logic [CW-1:0] pw_sh,
  output logic          pwm
);
  logic [CW-1:0] last;
  logic          wrap;

  always_comb begin
    last = (per_act == '0) ? '0 : per_act - 1'b1;
    wrap = (cnt == last);
    pwm  = (cnt < pw_act);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      per_act <= RST_PER;
      per_sh  <= RST_PER;
      pw_act  <= '0;
      pw_sh   <= '0;
    end else begin
      if (per_we) per_sh <= per_in;
      if (pw_we)  pw_sh  <= pw_in;
      if (wrap) begin
        cnt     <= '0;
        per_act <= per_sh;
        pw_act  <= pw_sh;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwmdac_modsel.sv
module pwmdac_modsel #(
  parameter int unsigned NS = 8,
  parameter int unsigned SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_code,
  input  logic          cfg_sign,
  input  logic [NS-1:0] src,
  output logic [SW-1:0] sel_q,
  output logic          sign_q,
  output logic          pol
);
  logic [NS-1:0] hit;
  logic          picked;

  for (genvar i = 0; i < NS; i++) begin : g_src
    assign hit[i] = (sel_q == SW'(i + 1)) & src[i];
  end

  assign picked = |hit;
  assign pol    = picked ^ sign_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      sign_q <= 1'b0;
    end else if (cfg_we) begin
      sel_q  <= cfg_code;
      sign_q <= cfg_sign;
    end
  end
endmodule

// File: rtl/pwmdac_ctrl.sv
module pwmdac_ctrl
  import pwmdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CNT_W-1:0]  req_value,
  input  logic [CNT_W:0]    cal_zero,
  input  logic [GAIN_W-1:0] cal_gain,
  input  logic              per_we,
  input  logic [CNT_W-1:0]  per_value,
  input  logic              mod_we,
  input  logic [SEL_W-1:0]  mod_code,
  input  logic              mod_sign,
  input  logic [NEXT-1:0]   mod_in,
  output logic              pwm_o,
  output logic              pwm_n_o,
  output logic              pol_o
);
  logic [CNT_W-1:0] cnt, per_act, pw_act, per_sh, pw_sh, code;
  logic [SEL_W-1:0] sel_q;
  logic             sign_q, pwm;
  logic [NSRC-1:0]  srcs;

  assign req_ready = 1'b1;

  pwmdac_cal #(.DW(CNT_W), .GW(GAIN_W), .FW(FRAC_W), .CW(CNT_W)) u_cal (
    .value(req_value), .gain(cal_gain), .zero(cal_zero),
    .limit(per_sh), .code(code)
  );

  pwmdac_core #(.CW(CNT_W), .RST_PER(DEF_PERIOD)) u_core (
    .clk(clk), .rst_n(rst_n),
    .per_we(per_we), .per_in(per_value),
    .pw_we(req_valid & req_ready), .pw_in(code),
    .cnt(cnt), .per_act(per_act), .pw_act(pw_act),
    .per_sh(per_sh), .pw_sh(pw_sh), .pwm(pwm)
  );

  assign pwm_o   = pwm;
  assign pwm_n_o = ~pwm;
  assign srcs    = {~pwm, pwm, mod_in};

  pwmdac_modsel #(.NS(NSRC), .SW(SEL_W)) u_mod (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(mod_we), .cfg_code(mod_code), .cfg_sign(mod_sign),
    .src(srcs), .sel_q(sel_q), .sign_q(sign_q), .pol(pol_o)
  );
endmodule

// File: rtl/pwmdac_ctrl_chk.sv
module pwmdac_ctrl_chk #(
  parameter int unsigned CW = 16,
  parameter int unsigned SW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] per_act,
  input logic [CW-1:0] pw_act,
  input logic [CW-1:0] per_sh,
  input logic [CW-1:0] pw_sh,
  input logic [SW-1:0] sel_q,
  input logic          sign_q,
  input logic          pwm_o,
  input logic          pol_o
);
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (per_act != '0) |-> (cnt < per_act));

  p_zero_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_act == '0) |-> !pwm_o);

  p_full_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (per_act != '0 && pw_act >= per_act) |-> pwm_o);

  p_pw_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pw_act) |-> (cnt == '0));

  p_per_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(per_act) |-> (cnt == '0));

  p_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (pw_sh <= $past(per_sh)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(pw_sh));

  p_off_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == '0 || sel_q > SW'(8)) |-> (pol_o == sign_q));
endmodule

bind pwmdac_ctrl pwmdac_ctrl_chk #(.CW(pwmdac_pkg::CNT_W), .SW(pwmdac_pkg::SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .cnt(cnt), .per_act(per_act), .pw_act(pw_act),
  .per_sh(per_sh), .pw_sh(pw_sh), .sel_q(sel_q), .sign_q(sign_q),
  .pwm_o(pwm_o), .pol_o(pol_o)
);

// File: tb/sim_pwmdac_ctrl.sv
`timescale 1ns/1ps
module sim_pwmdac_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_value = '0;
  logic [16:0] cal_zero = '0;
  logic [15:0] cal_gain = 16'd256;
  logic        per_we = 1'b0;
  logic [15:0] per_value = '0;
  logic        mod_we = 1'b0;
  logic [3:0]  mod_code = '0;
  logic        mod_sign = 1'b0;
  logic [5:0]  mod_in = '0;
  logic        pwm_o, pwm_n_o, pol_o;

  always #2.5 clk = ~clk;

  pwmdac_ctrl u0 (.*);

  int checks = 0, errors = 0, cyc = 0;
  string tag = "R11";
  bit live = 0;

  // behavioural reference state
  int m_cnt, m_per, m_pw, m_per_sh, m_pw_sh, m_sel, m_sign;

  function automatic int cal_code(int v, int g, int z, int lim);
    longint t;
    t = ((longint'(v) * longint'(g) + 128) >>> 8) + longint'(z);
    if (t < 0) return 0;
    if (t > lim) return lim;
    return int'(t);
  endfunction

  always @(posedge clk) begin
    int o_per_sh, o_pw_sh, last;
    cyc++;
    if (!rst_n) begin
      m_cnt = 0; m_per = 4095; m_per_sh = 4095; m_pw = 0; m_pw_sh = 0;
      m_sel = 0; m_sign = 0;
    end else begin
      o_per_sh = m_per_sh; o_pw_sh = m_pw_sh;
      if (req_valid) m_pw_sh = cal_code(req_value, cal_gain, $signed(cal_zero), o_per_sh);
      if (per_we) m_per_sh = per_value;
      if (mod_we) begin m_sel = mod_code; m_sign = mod_sign; end
      last = (m_per == 0) ? 0 : m_per - 1;
      if (m_cnt == last) begin
        m_cnt = 0; m_per = o_per_sh; m_pw = o_pw_sh;
      end else m_cnt++;
    end
    live = 1;
    if (cyc > 200000) begin
      errors++;
      $display("FAIL watchdog: actual cycles %0d expected < 200000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic bit exp_pwm();
    return m_cnt < m_pw;
  endfunction

  function automatic bit exp_pol();
    bit [7:0] s;
    bit pick;
    s = {~exp_pwm(), exp_pwm(), mod_in};
    pick = (m_sel >= 1 && m_sel <= 8) ? s[m_sel-1] : 1'b0;
    return pick ^ m_sign[0];
  endfunction

  always @(negedge clk) if (live) begin
    checks++;
    if (pwm_o !== exp_pwm()) begin
      errors++; $display("FAIL %s pwm_o: actual %0b expected %0b (cnt %0d)", tag, pwm_o, exp_pwm(), m_cnt);
    end
    if (pwm_n_o !== ~exp_pwm()) begin
      errors++; $display("FAIL R4 pwm_n_o: actual %0b expected %0b", pwm_n_o, ~exp_pwm());
    end
    if (pol_o !== exp_pol()) begin
      errors++; $display("FAIL %s pol_o: actual %0b expected %0b", tag, pol_o, exp_pol());
    end
    if (req_ready !== 1'b1) begin
      errors++; $display("FAIL R8 req_ready: actual %0b expected 1", req_ready);
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
    #1;
    req_valid = 0; per_we = 0; mod_we = 0;
  endtask

  task automatic request(int v);
    @(negedge clk); #1;
    req_value = 16'(v); req_valid = 1; per_we = 0; mod_we = 0;
  endtask

  task automatic set_period(int p);
    @(negedge clk); #1;
    per_value = 16'(p); per_we = 1; req_valid = 0; mod_we = 0;
  endtask

  task automatic duty_check(int p, int want, string t);
    int highs = 0;
    @(negedge clk);
    while (m_cnt != 0) @(negedge clk);
    for (int i = 0; i < p; i++) begin
      highs += pwm_o;
      @(negedge clk);
    end
    checks++;
    if (highs != want) begin
      errors++; $display("FAIL %s duty: actual %0d expected %0d", t, highs, want);
    end
    #1;
  endtask

  initial begin
    step(3);
    checks++;
    if (pwm_o !== 1'b0 || pwm_n_o !== 1'b1 || pol_o !== 1'b0) begin
      errors++; $display("FAIL R11 reset outputs: actual %0b%0b%0b expected 010", pwm_o, pwm_n_o, pol_o);
    end
    rst_n = 1;
    tag = "R5";
    set_period(10);           // pending only; default 4095 still runs
    step(20);
    tag = "R1";
    step(4090);
    tag = "R6";
    cal_gain = 16'd256; cal_zero = '0;
    request(3); step(1);
    step(25);
    duty_check(10, 3, "R2");
    tag = "R3";
    request(0); step(25);
    duty_check(10, 0, "R3");
    tag = "R7";
    request(20); step(25);
    duty_check(10, 10, "R3");
    cal_zero = -17'sd50;
    request(5); step(25);
    duty_check(10, 0, "R7");
    tag = "R6";
    cal_zero = '0; cal_gain = 16'd384;
    request(5); step(25);
    duty_check(10, 8, "R6");
    cal_gain = 16'd256; cal_zero = 17'd2;
    request(2); step(1); request(4); step(25);
    duty_check(10, 6, "R8");
    tag = "R5";
    step(3);
    set_period(7); step(30);
    duty_check(7, 6, "R5");
    tag = "R1";
    set_period(0); step(10);
    request(3); step(10);
    set_period(7); request(1); step(30);
    duty_check(7, 3, "R1");
    tag = "R9";
    for (int c = 0; c < 16; c++) begin
      for (int s = 0; s < 2; s++) begin
        @(negedge clk); #1;
        mod_code = 4'(c); mod_sign = s[0]; mod_we = 1;
        mod_in = 6'b101001;
        step(4);
        mod_in = 6'b010110;
        step(4);
      end
    end
    tag = "R10";
    @(negedge clk); #1; mod_code = 4'd7; mod_sign = 1; mod_we = 1;
    step(20);
    @(negedge clk); #1; mod_code = 4'd1; mod_sign = 0; mod_we = 1;
    mod_in = 6'b000001; step(3);
    checks++;
    if (pol_o !== 1'b1) begin
      errors++; $display("FAIL R10 pol_o code1: actual %0b expected 1", pol_o);
    end
    step(5);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule